// File: doc/BRIEF.md
# Banked Data Address Generator

This block produces the 12-bit data-memory address for an 8-bit microcontroller's register file, one request per clock. Each request names an access kind. A direct request combines an 8-bit file field with either the current bank register or a fixed access bank. The access bank is split: small file values reach general RAM at the bottom of bank 0, and large ones reach the special-function registers at the top of bank 15. Immediate and inherent operations need no address and only clear the valid flag. An indirect request reads one of several pointer registers. A pre-increment request first advances that pointer by one and then uses the advanced value.

The bank register has its own write port. Each pointer register is loaded from a full-width literal through a separate load port. The resolved address and its valid flag are registered and appear one clock after the request. The storage behind the address is outside the block.

Top module: `data_addr_gen`

## Requirements
- R1: During reset and in the first cycle after it, `addr_o` is 0 and `addr_vld` is 0. Reset clears the bank register and all three pointers to 0.
- R2: The result for a request presented in cycle k appears on `addr_o`/`addr_vld` after the clock edge that ends cycle k, and it holds until the next edge.
- R3: The `kind` encoding is 2'b00 none (immediate/inherent), 2'b01 direct, 2'b10 indirect and 2'b11 pre-increment indirect. Kind 2'b00 gives `addr_vld`=0 and `addr_o`=0.
- R4: A direct request with `acc_sel`=0 gives address {bank[3:0], file_addr[7:0]} with `addr_vld`=1.
- R5: A direct request with `acc_sel`=1 and `file_addr` below 0x60 gives address 0x000 + `file_addr`.
- R6: A direct request with `acc_sel`=1 and `file_addr` of 0x60 or more gives address 0xF00 + `file_addr`, whatever the bank register holds.
- R7: A bank write (`bank_we`) takes effect for requests in the following cycle. A direct request in the same cycle as the write uses the old bank.
- R8: An indirect request gives the selected pointer's value as the address and leaves the pointer unchanged.
- R9: A pre-increment request gives the selected pointer plus one, modulo 4096, as the address, and stores that value back into the pointer. 0xFFF wraps to 0x000.
- R10: A pointer load (`ptr_ld`) writes `ptr_ld_val` into pointer `ptr_ld_idx`, visible to requests from the next cycle. An access in the load cycle uses the old value.
- R11: When a load and a pre-increment target the same pointer in one cycle, the pointer takes the loaded literal. The address for that cycle is still the old value plus one.
- R12: Pointer index 3 does not exist. An indirect or pre-increment request to it gives `addr_vld`=0 and `addr_o`=0, and a load to it changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kind | input | 2 | Access kind of the current request |
| file_addr | input | 8 | File field of a direct request |
| acc_sel | input | 1 | 1 selects the access bank, 0 the bank register |
| ptr_idx | input | 2 | Pointer used by an indirect request |
| bank_we | input | 1 | Bank register write enable |
| bank_wdata | input | 4 | New bank number |
| ptr_ld | input | 1 | Pointer load enable |
| ptr_ld_idx | input | 2 | Pointer to load |
| ptr_ld_val | input | 12 | Literal loaded into the pointer |
| addr_o | output | 12 | Resolved data address |
| addr_vld | output | 1 | Address is meaningful |

## Verification
A pre-increment and a literal load can land on the same pointer in one cycle. In that cycle the address must come from the old pointer, while the stored value must come from the load. The bench provokes this by pairing `ptr_ld` with a pre-increment to the same index, and separately to a different index. It then judges the stored value by issuing a plain indirect request on the next cycle. A bank write together with a direct request is a second same-cycle pairing: the old bank must appear in the address. Random traffic mixes both pairings, and a behavioural model compares the outputs on every clock.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [1:0] {
      AK_NONE   = 2'b00,
      AK_DIRECT = 2'b01,
      AK_INDIR  = 2'b10,
      AK_PREINC = 2'b11
   } acc_kind_e;
endpackage

// File: rtl/dag_bank_reg.sv
module dag_bank_reg #(
   parameter int BANK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] bank_q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         bank_q <= '0;
      else if (we)
         bank_q <= wdata;
   end
endmodule

// File: rtl/dag_ptr_file.sv
module dag_ptr_file #(
   parameter int NUM_PTR = 3,
   parameter int ADDR_W  = 12,
   parameter int IDX_W   = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld,
   input  logic [IDX_W-1:0]          ld_idx,
   input  logic [ADDR_W-1:0]         ld_val,
   input  logic                      inc,
   input  logic [IDX_W-1:0]          inc_idx,
   output logic [NUM_PTR*ADDR_W-1:0] ptr_flat
);
   for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
      logic [ADDR_W-1:0] q;
      logic              hit_ld;
      logic              hit_inc;

      assign hit_ld  = ld  && (ld_idx  == IDX_W'(g));
      assign hit_inc = inc && (inc_idx == IDX_W'(g));

      // a literal load outranks an increment of the same pointer
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (hit_ld)
            q <= ld_val;
         else if (hit_inc)
            q <= q + ADDR_W'(1);
      end

      assign ptr_flat[g*ADDR_W +: ADDR_W] = q;
   end
endmodule

// File: rtl/dag_resolve.sv
module dag_resolve
   import dag_pkg::*;
#(
   parameter int FILE_W    = 8,
   parameter int BANK_W    = 4,
   parameter int NUM_PTR   = 3,
   parameter int IDX_W     = 2,
   parameter int ACC_SPLIT = 'h60,
   localparam int ADDR_W   = BANK_W + FILE_W
) (
   input  acc_kind_e                 kind,
   input  logic                      acc_sel,
   input  logic [FILE_W-1:0]         file_addr,
   input  logic [BANK_W-1:0]         bank_q,
   input  logic [IDX_W-1:0]          ptr_idx,
   input  logic [NUM_PTR*ADDR_W-1:0] ptr_flat,
   output logic [ADDR_W-1:0]         addr,
   output logic                      vld,
   output logic                      inc_req
);
   localparam logic [FILE_W:0] SPLIT_V = ACC_SPLIT[FILE_W:0];

   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] bank_addr;
   logic [ADDR_W-1:0] sel_ptr;
   logic              idx_ok;

   // access-bank mapping variant chosen from the split point
   if (ACC_SPLIT == 0) begin : g_all_high
      assign acc_addr = {{BANK_W{1'b1}}, file_addr};
   end else if (ACC_SPLIT == (1 << FILE_W)) begin : g_all_low
      assign acc_addr = {{BANK_W{1'b0}}, file_addr};
   end else begin : g_split
      logic low_half;
      assign low_half = ({1'b0, file_addr} < SPLIT_V);
      assign acc_addr = low_half ? {{BANK_W{1'b0}}, file_addr}
                                 : {{BANK_W{1'b1}}, file_addr};
   end

   assign bank_addr = {bank_q, file_addr};

   always_comb begin
      sel_ptr = '0;
      idx_ok  = 1'b0;
      for (int i = 0; i < NUM_PTR; i++) begin
         if (ptr_idx == IDX_W'(i)) begin
            sel_ptr = ptr_flat[i*ADDR_W +: ADDR_W];
            idx_ok  = 1'b1;
         end
      end
   end

   always_comb begin
      addr    = '0;
      vld     = 1'b0;
      inc_req = 1'b0;
      unique case (kind)
         AK_NONE: begin
            addr = '0;
            vld  = 1'b0;
         end
         AK_DIRECT: begin
            addr = acc_sel ? acc_addr : bank_addr;
            vld  = 1'b1;
         end
         AK_INDIR: begin
            addr = idx_ok ? sel_ptr : '0;
            vld  = idx_ok;
         end
         AK_PREINC: begin
            addr    = idx_ok ? (sel_ptr + ADDR_W'(1)) : '0;
            vld     = idx_ok;
            inc_req = idx_ok;
         end
         default: begin
            addr = '0;
            vld  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen
   import dag_pkg::*;
#(
   parameter int FILE_W    = 8,
   parameter int BANK_W    = 4,
   parameter int NUM_PTR   = 3,
   parameter int ACC_SPLIT = 'h60,
   parameter bit REG_OUT   = 1'b1,
   localparam int ADDR_W   = BANK_W + FILE_W,
   localparam int IDX_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        kind,
   input  logic [FILE_W-1:0] file_addr,
   input  logic              acc_sel,
   input  logic [IDX_W-1:0]  ptr_idx,
   input  logic              bank_we,
   input  logic [BANK_W-1:0] bank_wdata,
   input  logic              ptr_ld,
   input  logic [IDX_W-1:0]  ptr_ld_idx,
   input  logic [ADDR_W-1:0] ptr_ld_val,
   output logic [ADDR_W-1:0] addr_o,
   output logic              addr_vld
);
   if (FILE_W < 1 || BANK_W < 1) begin : g_bad_width
      $error("data_addr_gen: FILE_W and BANK_W must be positive");
   end
   if (NUM_PTR < 1) begin : g_bad_ptr
      $error("data_addr_gen: NUM_PTR must be at least 1");
   end
   if (ACC_SPLIT < 0 || ACC_SPLIT > (1 << FILE_W)) begin : g_bad_split
      $error("data_addr_gen: ACC_SPLIT outside the file field range");
   end

   logic [BANK_W-1:0]         bank_q;
   logic [NUM_PTR*ADDR_W-1:0] ptr_flat;
   logic [ADDR_W-1:0]         nxt_addr;
   logic                      nxt_vld;
   logic                      inc_req;

   dag_bank_reg #(.BANK_W(BANK_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bank_we),
      .wdata  (bank_wdata),
      .bank_q (bank_q)
   );

   dag_ptr_file #(
      .NUM_PTR (NUM_PTR),
      .ADDR_W  (ADDR_W),
      .IDX_W   (IDX_W)
   ) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (ptr_ld),
      .ld_idx   (ptr_ld_idx),
      .ld_val   (ptr_ld_val),
      .inc      (inc_req),
      .inc_idx  (ptr_idx),
      .ptr_flat (ptr_flat)
   );

   dag_resolve #(
      .FILE_W    (FILE_W),
      .BANK_W    (BANK_W),
      .NUM_PTR   (NUM_PTR),
      .IDX_W     (IDX_W),
      .ACC_SPLIT (ACC_SPLIT)
   ) u_res (
      .kind      (acc_kind_e'(kind)),
      .acc_sel   (acc_sel),
      .file_addr (file_addr),
      .bank_q    (bank_q),
      .ptr_idx   (ptr_idx),
      .ptr_flat  (ptr_flat),
      .addr      (nxt_addr),
      .vld       (nxt_vld),
      .inc_req   (inc_req)
   );

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            addr_o   <= '0;
            addr_vld <= 1'b0;
         end else begin
            addr_o   <= nxt_addr;
            addr_vld <= nxt_vld;
         end
      end
   end else begin : g_comb_out
      assign addr_o   = nxt_addr;
      assign addr_vld = nxt_vld;
   end
endmodule

// File: rtl/data_addr_gen_chk.sv
module data_addr_gen_chk #(
   parameter int FILE_W    = 8,
   parameter int BANK_W    = 4,
   parameter int NUM_PTR   = 3,
   parameter int ACC_SPLIT = 'h60,
   parameter bit REG_OUT   = 1'b1,
   localparam int ADDR_W   = BANK_W + FILE_W,
   localparam int IDX_W    = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        kind,
   input logic [FILE_W-1:0] file_addr,
   input logic              acc_sel,
   input logic [IDX_W-1:0]  ptr_idx,
   input logic              bank_we,
   input logic [BANK_W-1:0] bank_wdata,
   input logic              ptr_ld,
   input logic [IDX_W-1:0]  ptr_ld_idx,
   input logic [ADDR_W-1:0] ptr_ld_val,
   input logic [ADDR_W-1:0] addr_o,
   input logic              addr_vld
);
   localparam logic [FILE_W:0] SPLIT_V = ACC_SPLIT[FILE_W:0];

   logic              idx_ok;
   logic              same_tgt;
   logic              r_pre;
   logic              r_coll;
   logic [IDX_W-1:0]  r_idx;
   logic [ADDR_W-1:0] r_val;

   assign idx_ok   = ({1'b0, ptr_idx} < (IDX_W+1)'(NUM_PTR));
   assign same_tgt = ptr_ld && (ptr_ld_idx == ptr_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         r_pre  <= 1'b0;
         r_coll <= 1'b0;
         r_idx  <= '0;
         r_val  <= '0;
      end else begin
         r_pre  <= (kind == 2'b11) && idx_ok && !same_tgt;
         r_coll <= (kind == 2'b11) && idx_ok && same_tgt;
         r_idx  <= ptr_idx;
         r_val  <= ptr_ld_val;
      end
   end

   if (REG_OUT) begin : g_props
      p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (kind == 2'b00) |=> (!addr_vld && addr_o == '0));

      p_bank_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (kind == 2'b01 && !acc_sel) |=> (addr_vld && addr_o[FILE_W-1:0] == $past(file_addr)));

      p_acc_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (kind == 2'b01 && acc_sel && ({1'b0, file_addr} < SPLIT_V))
         |=> (addr_o == {{BANK_W{1'b0}}, $past(file_addr)}));

      p_acc_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (kind == 2'b01 && acc_sel && !({1'b0, file_addr} < SPLIT_V))
         |=> (addr_o == {{BANK_W{1'b1}}, $past(file_addr)}));

      p_preinc_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (r_pre && kind == 2'b10 && ptr_idx == r_idx) |=> (addr_o == $past(addr_o)));

      p_load_prio_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (r_coll && kind == 2'b10 && ptr_idx == r_idx) |=> (addr_o == $past(r_val)));

      p_badidx_r12: assert property (@(posedge clk) disable iff (!rst_n)
         (kind[1] && !idx_ok) |=> (!addr_vld && addr_o == '0));
   end
endmodule

bind data_addr_gen data_addr_gen_chk #(
   .FILE_W    (FILE_W),
   .BANK_W    (BANK_W),
   .NUM_PTR   (NUM_PTR),
   .ACC_SPLIT (ACC_SPLIT),
   .REG_OUT   (REG_OUT)
) u_chk (.*);

// File: tb/data_addr_gen_tb.sv
module data_addr_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  kind = 2'b00;
   logic [7:0]  file_addr = '0;
   logic        acc_sel = 1'b0;
   logic [1:0]  ptr_idx = '0;
   logic        bank_we = 1'b0;
   logic [3:0]  bank_wdata = '0;
   logic        ptr_ld = 1'b0;
   logic [1:0]  ptr_ld_idx = '0;
   logic [11:0] ptr_ld_val = '0;
   logic [11:0] addr_o;
   logic        addr_vld;

   int checks = 0;
   int errors = 0;
   int m_bank = 0;
   int m_ptr [3] = '{0, 0, 0};
   int exp_addr = 0;
   int exp_vld = 0;

   always #4 clk = ~clk;

   data_addr_gen u_dut (
      .clk(clk), .rst_n(rst_n), .kind(kind), .file_addr(file_addr),
      .acc_sel(acc_sel), .ptr_idx(ptr_idx), .bank_we(bank_we),
      .bank_wdata(bank_wdata), .ptr_ld(ptr_ld), .ptr_ld_idx(ptr_ld_idx),
      .ptr_ld_val(ptr_ld_val), .addr_o(addr_o), .addr_vld(addr_vld)
   );

   task automatic compare(input string tag);
      checks++;
      if (int'(addr_o) != exp_addr || int'(addr_vld) != exp_vld) begin
         errors++;
         $display("FAIL %s: addr=%03h vld=%0d expected addr=%03h vld=%0d",
                  tag, addr_o, addr_vld, exp_addr, exp_vld);
      end
   endtask

   // drive one request at the falling edge, predict, clock, compare
   task automatic cyc(input logic [1:0] k, input logic [7:0] f, input logic a,
                      input logic [1:0] pi, input logic bw, input logic [3:0] bd,
                      input logic pl, input logic [1:0] pli, input logic [11:0] plv,
                      input string tag);
      kind = k; file_addr = f; acc_sel = a; ptr_idx = pi;
      bank_we = bw; bank_wdata = bd; ptr_ld = pl; ptr_ld_idx = pli; ptr_ld_val = plv;
      exp_addr = 0; exp_vld = 0;
      case (k)
         2'b01: begin
            exp_vld = 1;
            if (a) exp_addr = (f < 8'h60) ? int'(f) : ('hF00 + int'(f));
            else   exp_addr = m_bank * 256 + int'(f);
         end
         2'b10: if (pi < 3) begin exp_vld = 1; exp_addr = m_ptr[pi]; end
         2'b11: if (pi < 3) begin exp_vld = 1; exp_addr = (m_ptr[pi] + 1) % 4096; end
         default: ;
      endcase
      @(posedge clk);
      if (bw) m_bank = int'(bd);
      if (k == 2'b11 && pi < 3) m_ptr[pi] = (m_ptr[pi] + 1) % 4096;
      if (pl && pli < 3) m_ptr[pli] = int'(plv);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: addr=%03h vld=%0d expected run to end", addr_o, addr_vld);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      exp_addr = 0; exp_vld = 0;
      compare("R1 in reset");
      rst_n = 1'b1;
      compare("R1 first cycle after reset");
      cyc(2'b01, 8'h34, 0, 0, 0, 0, 0, 0, 0, "R1 bank cleared");
      for (int i = 0; i < 3; i++) cyc(2'b10, 0, 0, 2'(i), 0, 0, 0, 0, 0, "R1 pointer cleared");
      cyc(2'b00, 8'hAA, 1, 0, 0, 0, 0, 0, 0, "R3 none kind");
      // bank write with direct in the same cycle uses old bank
      cyc(2'b01, 8'h12, 0, 0, 1, 4'h5, 0, 0, 0, "R7 old bank in write cycle");
      cyc(2'b01, 8'h12, 0, 0, 0, 0, 0, 0, 0, "R4 banked new bank");
      cyc(2'b01, 8'hFF, 0, 0, 1, 4'hF, 0, 0, 0, "R4 banked top byte");
      cyc(2'b01, 8'h00, 0, 0, 0, 0, 0, 0, 0, "R4 bank 15 bottom");
      cyc(2'b01, 8'h5F, 1, 0, 0, 0, 0, 0, 0, "R5 access low edge");
      cyc(2'b01, 8'h00, 1, 0, 0, 0, 0, 0, 0, "R5 access zero");
      cyc(2'b01, 8'h60, 1, 0, 1, 4'h3, 0, 0, 0, "R6 access high edge");
      cyc(2'b01, 8'hFF, 1, 0, 0, 0, 0, 0, 0, "R6 access top ignores bank");
      // pointer loads and plain indirect
      cyc(2'b10, 0, 0, 1, 0, 0, 1, 1, 12'h123, "R10 old value in load cycle");
      cyc(2'b10, 0, 0, 1, 0, 0, 0, 0, 0, "R10 loaded value");
      cyc(2'b10, 0, 0, 1, 0, 0, 0, 0, 0, "R8 indirect leaves pointer");
      cyc(2'b11, 0, 0, 1, 0, 0, 0, 0, 0, "R9 preinc address");
      cyc(2'b10, 0, 0, 1, 0, 0, 0, 0, 0, "R9 preinc stored");
      cyc(2'b00, 0, 0, 0, 0, 0, 1, 2, 12'hFFF, "R10 load top");
      cyc(2'b11, 0, 0, 2, 0, 0, 0, 0, 0, "R9 wrap to zero");
      cyc(2'b10, 0, 0, 2, 0, 0, 0, 0, 0, "R9 wrapped pointer");
      // same-pointer collision
      cyc(2'b11, 0, 0, 0, 0, 0, 1, 0, 12'h7A0, "R11 address from old pointer");
      cyc(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, "R11 load wins");
      cyc(2'b11, 0, 0, 1, 0, 0, 1, 0, 12'h055, "R11 different pointers both apply");
      cyc(2'b10, 0, 0, 0, 0, 0, 0, 0, 0, "R11 other pointer loaded");
      cyc(2'b10, 0, 0, 1, 0, 0, 0, 0, 0, "R11 incremented pointer kept");
      // nonexistent pointer
      cyc(2'b10, 0, 0, 3, 0, 0, 0, 0, 0, "R12 indirect to index 3");
      cyc(2'b11, 0, 0, 3, 0, 0, 1, 3, 12'hABC, "R12 preinc and load to index 3");
      for (int i = 0; i < 3; i++) cyc(2'b10, 0, 0, 2'(i), 0, 0, 0, 0, 0, "R12 pointers untouched");
      // mixed traffic
      for (int n = 0; n < 600; n++) begin
         cyc(2'($urandom), 8'($urandom), 1'($urandom), 2'($urandom),
             ($urandom % 4) == 0, 4'($urandom), ($urandom % 3) == 0,
             2'($urandom), 12'($urandom), "R2 random traffic");
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule